// File: doc/BRIEF.md
# Handshaking Parallel Port

This block gives a host CPU three 8-bit peripheral ports, called A, B and C. The host reaches the ports through an 8-bit data bus. The bus has an active-low chip select, active-low read and write strobes and a two-bit address. A control word sets the direction and mode of two groups. The first group is port A plus the upper nibble of C. The second group is port B plus the lower nibble of C.

Each group runs in one of two modes:
- In plain mode, the ports are simple latched outputs or transparent inputs.
- In strobed mode, the group's 8-bit port moves data under a handshake. Some port C lines then carry the handshake flags, so the peripheral and the host can trade bytes without polling timing.

A second kind of control word changes one bit of port C without touching the other seven bits. The same word arms each strobed port's interrupt flag.

The host strobes and the handshake pins are asynchronous. They pass through a two-stage synchroniser, and every flag update happens on an edge seen in that synchronised view. Pads are split into separate input, output and output-enable vectors.

Top module: `pport_hs`

## Requirements
- R1: Reset sets the control word to 8'h9B. Reading address 3 then returns 9B, every port output enable is low, and all latches and flags are zero.
- R2: With cs_n low, address 0, 1, 2 and 3 select port A, port B, port C and the control word. A write takes effect when wr_n rises. `dout_en` is high only while cs_n and rd_n are both low. A write with cs_n high changes nothing.
- R3: Plain mode directions come from the control word: bit 4 for A, bit 3 for C[7:4], bit 1 for B, bit 0 for C[3:0], with 1 meaning input. An output port drives and reads back its written latch. An input port reads its pins live, with no latching.
- R4: A control write with bit 7 = 1 is a mode word. Bits 6:5 nonzero make group A strobed and bit 2 makes group B strobed. A mode word clears every output latch, handshake flag and interrupt enable.
- R5: A control write with bit 7 = 0 sets port C bit number din[3:1] to din[0] and leaves the other bits unchanged.
- R6: A strobed input for port A works as follows:
  - A low on C4 captures pa_in into a latch and raises the buffer-full flag on C5.
  - A later rising edge of rd_n on port A clears the flag.
  - A read of port A returns the latched byte.
- R7: The input-side interrupt on C3 rises when the strobe returns high with the flag full and the enable set. It clears on the falling edge of rd_n addressed to the port.
- R8: In strobed output on port A, writing port A drives the active-low output-full line C7 low. A low acknowledge on C6 returns it high.
- R9: The output-side interrupt on C3 rises when the acknowledge returns high with the enable set. It clears on the falling edge of wr_n addressed to the port.
- R10: In strobed mode, port B uses three lines:
  - C2 is its strobe or acknowledge.
  - C1 is its buffer-full flag (input) or active-low output-full (output).
  - C0 is its interrupt.
  Its enable is written as bit 2 by a bit-set word, just as the port A enable is written as bit 4.
- R11: While a port's interrupt enable is clear, its interrupt output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| cs_n | input | 1 | active-low chip select |
| rd_n | input | 1 | active-low read strobe |
| wr_n | input | 1 | active-low write strobe |
| addr | input | 2 | register select |
| din | input | 8 | host write data |
| dout | output | 8 | host read data |
| dout_en | output | 1 | host data bus drive enable |
| pa_in | input | 8 | port A pad input |
| pa_out | output | 8 | port A pad output |
| pa_oe | output | 8 | port A pad output enable |
| pb_in | input | 8 | port B pad input |
| pb_out | output | 8 | port B pad output |
| pb_oe | output | 8 | port B pad output enable |
| pc_in | input | 8 | port C pad input |
| pc_out | output | 8 | port C pad output |
| pc_oe | output | 8 | port C pad output enable |

## Verification
The checks assume that cs_n, addr and din stay stable from the falling edge of a strobe until several clocks after it rises. Decode and data are sampled on the synchronised strobe edge, so they must still hold at that point. The assertions also assume that a handshake pin holds each level for at least two clocks, so the synchroniser sees every edge. The bench drives every bus cycle through tasks that hold address and data for five clocks after the strobe rises. It holds every strobe or acknowledge pulse for six clocks.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int unsigned DW = 8;
    localparam logic [DW-1:0] CTRL_RESET = 8'h9B;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    typedef struct packed {
        logic       is_mode;
        logic [1:0] a_mode;
        logic       a_in;
        logic       cu_in;
        logic       b_mode;
        logic       b_in;
        logic       cl_in;
    } ctrl_t;

    // bit number addressed by a single-bit port C word
    function automatic logic [2:0] bsr_index(input logic [DW-1:0] w);
        return w[3:1];
    endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[LAST];
endmodule

// File: rtl/pport_chan.sv
module pport_chan #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          act,
    input  logic          is_out,
    input  logic          inte,
    input  logic          strb_n,
    input  logic          strb_rise,
    input  logic          host_fall,
    input  logic          host_rise,
    input  logic          data_wr,
    input  logic [DW-1:0] pin_in,
    output logic          flag,
    output logic          intr,
    output logic [DW-1:0] in_lat
);
    always_ff @(posedge clk) begin
        if (rst || clr || !act) begin
            flag   <= 1'b0;
            in_lat <= '0;
        end else if (!is_out) begin
            if (!strb_n) begin
                flag   <= 1'b1;
                in_lat <= pin_in;
            end else if (host_rise) begin
                flag <= 1'b0;
            end
        end else begin
            if (!strb_n) begin
                flag <= 1'b0;
            end else if (data_wr) begin
                flag <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr || !act || !inte || host_fall) begin
            intr <= 1'b0;
        end else if (strb_rise && (is_out ? !flag : flag)) begin
            intr <= 1'b1;
        end
    end

    // R6
    ibf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (act && !is_out && !strb_n && !clr) |=> flag);

    // R8
    obf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (act && is_out && !strb_n && !clr) |=> !flag);

    // R7
    intr_host_clear_chk: assert property (@(posedge clk) disable iff (rst)
        host_fall |=> !intr);

    // R11
    intr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !inte |=> !intr);
endmodule

// File: rtl/pport_hs.sv
module pport_hs
    import pport_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);
    localparam int unsigned NS    = 5;
    localparam int unsigned NCH   = 2;
    localparam logic [2:0]  INTE_A_BIT = 3'd4;
    localparam logic [2:0]  INTE_B_BIT = 3'd2;

    // synchronised strobes: 0 rd, 1 wr, 2 C2, 3 C4, 4 C6
    logic [NS-1:0] s_lvl, s_prev;

    pport_sync #(.W(NS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pc_in[6], pc_in[4], pc_in[2], wr_n, rd_n}),
        .q   (s_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) s_prev <= '1;
        else     s_prev <= s_lvl;
    end

    logic rd_fall, rd_rise, wr_fall, wr_rise;
    logic c2_rise, c4_rise, c6_rise;
    assign rd_fall = !s_lvl[0] &&  s_prev[0];
    assign rd_rise =  s_lvl[0] && !s_prev[0];
    assign wr_fall = !s_lvl[1] &&  s_prev[1];
    assign wr_rise =  s_lvl[1] && !s_prev[1];
    assign c2_rise =  s_lvl[2] && !s_prev[2];
    assign c4_rise =  s_lvl[3] && !s_prev[3];
    assign c6_rise =  s_lvl[4] && !s_prev[4];

    ctrl_t         ctrl;
    logic [DW-1:0] pa_lat, pb_lat, pc_lat;
    logic [NCH-1:0] inte;

    logic wr_ev, mode_wr, bsr_wr;
    assign wr_ev   = wr_rise && !cs_n;
    assign mode_wr = wr_ev && (sel_e'(addr) == SEL_CTRL) &&  din[7];
    assign bsr_wr  = wr_ev && (sel_e'(addr) == SEL_CTRL) && !din[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= ctrl_t'(CTRL_RESET);
            pa_lat <= '0;
            pb_lat <= '0;
            pc_lat <= '0;
            inte   <= '0;
        end else if (mode_wr) begin
            ctrl   <= ctrl_t'(din);
            pa_lat <= '0;
            pb_lat <= '0;
            pc_lat <= '0;
            inte   <= '0;
        end else if (bsr_wr) begin
            pc_lat[bsr_index(din)] <= din[0];
            if (bsr_index(din) == INTE_A_BIT) inte[0] <= din[0];
            if (bsr_index(din) == INTE_B_BIT) inte[1] <= din[0];
        end else if (wr_ev) begin
            case (sel_e'(addr))
                SEL_A:   pa_lat <= din;
                SEL_B:   pb_lat <= din;
                SEL_C:   pc_lat <= din;
                default: ;
            endcase
        end
    end

    logic a_strb, b_strb;
    assign a_strb = |ctrl.a_mode;
    assign b_strb = ctrl.b_mode;

    // per-channel wiring, index 0 = port A, index 1 = port B
    logic [NCH-1:0] ch_act, ch_out, ch_strb, ch_srise, ch_sel;
    logic [NCH-1:0] ch_hfall, ch_hrise, ch_dwr, ch_flag, ch_intr;
    logic [DW-1:0]  ch_pin [NCH];
    logic [DW-1:0]  ch_lat [NCH];

    always_comb begin
        ch_act[0]   = a_strb;
        ch_out[0]   = !ctrl.a_in;
        ch_strb[0]  = ch_out[0] ? s_lvl[4] : s_lvl[3];
        ch_srise[0] = ch_out[0] ? c6_rise  : c4_rise;
        ch_sel[0]   = !cs_n && (sel_e'(addr) == SEL_A);
        ch_pin[0]   = pa_in;
        ch_act[1]   = b_strb;
        ch_out[1]   = !ctrl.b_in;
        ch_strb[1]  = s_lvl[2];
        ch_srise[1] = c2_rise;
        ch_sel[1]   = !cs_n && (sel_e'(addr) == SEL_B);
        ch_pin[1]   = pb_in;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_hfall[g] = ch_sel[g] && (ch_out[g] ? wr_fall : rd_fall);
        assign ch_hrise[g] = ch_sel[g] && rd_rise;
        assign ch_dwr[g]   = ch_sel[g] && wr_rise;

        pport_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .clr       (mode_wr),
            .act       (ch_act[g]),
            .is_out    (ch_out[g]),
            .inte      (inte[g]),
            .strb_n    (ch_strb[g]),
            .strb_rise (ch_srise[g]),
            .host_fall (ch_hfall[g]),
            .host_rise (ch_hrise[g]),
            .data_wr   (ch_dwr[g]),
            .pin_in    (ch_pin[g]),
            .flag      (ch_flag[g]),
            .intr      (ch_intr[g]),
            .in_lat    (ch_lat[g])
        );
    end

    assign pa_out = pa_lat;
    assign pb_out = pb_lat;
    assign pa_oe  = {DW{!ctrl.a_in}};
    assign pb_oe  = {DW{!ctrl.b_in}};

    always_comb begin
        pc_out = pc_lat;
        pc_oe  = {{4{!ctrl.cu_in}}, {4{!ctrl.cl_in}}};
        if (a_strb) begin
            pc_out[3] = ch_intr[0];
            pc_oe[3]  = 1'b1;
            if (ctrl.a_in) begin
                pc_out[5] = ch_flag[0];
                pc_oe[5]  = 1'b1;
                pc_oe[4]  = 1'b0;
            end else begin
                pc_out[7] = !ch_flag[0];
                pc_oe[7]  = 1'b1;
                pc_oe[6]  = 1'b0;
            end
        end
        if (b_strb) begin
            pc_out[0] = ch_intr[1];
            pc_oe[0]  = 1'b1;
            pc_out[1] = ctrl.b_in ? ch_flag[1] : !ch_flag[1];
            pc_oe[1]  = 1'b1;
            pc_oe[2]  = 1'b0;
        end
    end

    logic [DW-1:0] rd_val;
    always_comb begin
        case (sel_e'(addr))
            SEL_A:   rd_val = !ctrl.a_in ? pa_lat : (a_strb ? ch_lat[0] : pa_in);
            SEL_B:   rd_val = !ctrl.b_in ? pb_lat : (b_strb ? ch_lat[1] : pb_in);
            SEL_C:   rd_val = (pc_oe & pc_out) | (~pc_oe & pc_in);
            default: rd_val = DW'(ctrl);
        endcase
    end

    assign dout_en = !cs_n && !rd_n;
    assign dout    = dout_en ? rd_val : '0;

    // R4
    mode_clears_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (pa_out == '0 && pb_out == '0));
endmodule

// File: tb/pport_hs_test.sv
`timescale 1ns/1ps
module pport_hs_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, rd_n, wr_n;
    logic [1:0] addr;
    logic [7:0] din, dout, pa_in, pb_in, pc_in;
    logic       dout_en;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pport_hs uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // vector: {kind[1:0], addr[1:0], data[7:0], req[3:0]}
    // kind 0 = write, 1 = read and compare, 2 = set pa_in
    localparam int NV = 21;
    localparam logic [15:0] VEC [NV] = '{
        {2'd0, 2'd3, 8'h80, 4'd4}, {2'd0, 2'd0, 8'h5A, 4'd3},
        {2'd1, 2'd0, 8'h5A, 4'd3}, {2'd0, 2'd1, 8'hC3, 4'd2},
        {2'd1, 2'd1, 8'hC3, 4'd2}, {2'd0, 2'd2, 8'h96, 4'd2},
        {2'd1, 2'd2, 8'h96, 4'd2}, {2'd0, 2'd3, 8'h80, 4'd4},
        {2'd1, 2'd1, 8'h00, 4'd4}, {2'd0, 2'd3, 8'h0F, 4'd5},
        {2'd1, 2'd2, 8'h80, 4'd5}, {2'd0, 2'd3, 8'h09, 4'd5},
        {2'd1, 2'd2, 8'h90, 4'd5}, {2'd0, 2'd3, 8'h0E, 4'd5},
        {2'd1, 2'd2, 8'h10, 4'd5}, {2'd0, 2'd3, 8'h90, 4'd3},
        {2'd2, 2'd0, 8'h3C, 4'd3}, {2'd1, 2'd0, 8'h3C, 4'd3},
        {2'd2, 2'd0, 8'h71, 4'd3}, {2'd1, 2'd0, 8'h71, 4'd3},
        {2'd1, 2'd3, 8'h90, 4'd2}
    };

    function automatic string rname(input logic [3:0] n);
        case (n)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        addr = a; din = d; cs_n = sel_n;
        cyc(1); wr_n = 1'b0;
        cyc(4); wr_n = 1'b1;
        cyc(5); cs_n = 1'b1;
        cyc(1);
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; cs_n = 1'b0;
        cyc(1); rd_n = 1'b0;
        cyc(2); d = dout;
        cyc(3); rd_n = 1'b1;
        cyc(5); cs_n = 1'b1;
        cyc(1);
    endtask

    task automatic pulse_pc(input int bitn);
        @(negedge clk);
        pc_in[bitn] = 1'b0;
        cyc(6);
        pc_in[bitn] = 1'b1;
        cyc(6);
    endtask

    initial begin
        int cnt = 0;
        while (!done && cnt < 100000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cnt);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        addr = '0; din = '0; pa_in = '0; pb_in = '0; pc_in = 8'hFF;
        cyc(4);
        rst = 1'b0;
        cyc(2);

        // R1 reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R2 dout_en idle", {7'd0, dout_en}, 8'h00);
        bus_rd(2'd3, rv);
        chk("R1 ctrl", rv, 8'h9B);

        // table of plain-mode vectors
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][15:14])
                2'd0: bus_wr(VEC[i][13:12], VEC[i][11:4], 1'b0);
                2'd1: begin
                    bus_rd(VEC[i][13:12], rv);
                    chk(rname(VEC[i][3:0]), rv, VEC[i][11:4]);
                end
                default: begin
                    pa_in = VEC[i][11:4];
                    cyc(1);
                end
            endcase
        end

        // R2 write with cs_n high is ignored
        bus_wr(2'd3, 8'h80, 1'b0);
        bus_wr(2'd0, 8'h11, 1'b0);
        bus_wr(2'd0, 8'hEE, 1'b1);
        chk("R2 ignored write pa_out", pa_out, 8'h11);
        chk("R3 pa_oe output", pa_oe, 8'hFF);

        // R6/R7/R11 strobed input on port A
        bus_wr(2'd3, 8'hB0, 1'b0);
        pa_in = 8'hA7;
        pulse_pc(4);
        pa_in = 8'h00;
        chk("R6 ibf set", {7'd0, pc_out[5]}, 8'h01);
        chk("R6 ibf driven", {7'd0, pc_oe[5]}, 8'h01);
        chk("R11 intr held low", {7'd0, pc_out[3]}, 8'h00);
        bus_rd(2'd0, rv);
        chk("R6 latched data", rv, 8'hA7);
        chk("R6 ibf cleared", {7'd0, pc_out[5]}, 8'h00);
        bus_wr(2'd3, 8'h09, 1'b0);
        pa_in = 8'h42;
        pulse_pc(4);
        pa_in = 8'h00;
        chk("R7 intr set", {7'd0, pc_out[3]}, 8'h01);
        bus_rd(2'd0, rv);
        chk("R7 data", rv, 8'h42);
        chk("R7 intr cleared", {7'd0, pc_out[3]}, 8'h00);

        // R8/R9 strobed output on port A
        bus_wr(2'd3, 8'hA0, 1'b0);
        bus_wr(2'd3, 8'h09, 1'b0);
        bus_wr(2'd0, 8'h3E, 1'b0);
        chk("R8 obf_n low", {7'd0, pc_out[7]}, 8'h00);
        chk("R8 obf driven", {7'd0, pc_oe[7]}, 8'h01);
        chk("R8 data out", pa_out, 8'h3E);
        @(negedge clk);
        pc_in[6] = 1'b0;
        cyc(6);
        chk("R8 ack clears obf", {7'd0, pc_out[7]}, 8'h01);
        chk("R9 intr low during ack", {7'd0, pc_out[3]}, 8'h00);
        pc_in[6] = 1'b1;
        cyc(6);
        chk("R9 intr set", {7'd0, pc_out[3]}, 8'h01);
        bus_wr(2'd0, 8'h51, 1'b0);
        chk("R9 intr cleared by write", {7'd0, pc_out[3]}, 8'h00);
        chk("R8 obf_n low again", {7'd0, pc_out[7]}, 8'h00);

        // R10 strobed input on port B
        bus_wr(2'd3, 8'h86, 1'b0);
        bus_wr(2'd3, 8'h05, 1'b0);
        pb_in = 8'h5D;
        pulse_pc(2);
        pb_in = 8'h00;
        chk("R10 ibf_b", {7'd0, pc_out[1]}, 8'h01);
        chk("R10 intr_b", {7'd0, pc_out[0]}, 8'h01);
        bus_rd(2'd1, rv);
        chk("R10 data b", rv, 8'h5D);
        chk("R10 flags cleared", {6'd0, pc_out[1:0]}, 8'h00);

        // R4 mode word clears a pending flag
        pulse_pc(2);
        bus_wr(2'd3, 8'h86, 1'b0);
        chk("R4 flags cleared by mode", {6'd0, pc_out[1:0]}, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule